// File: doc/BRIEF.md
# Host and core flash lock arbiter

This block decides who may use an on-chip flash array that is shared by an external host port and an embedded core port. Reads from either side are arbitrated in hardware with alternating priority, and each granted read occupies the array for a fixed number of cycles. Program and erase sequences are exclusive: the core owns them out of reset, and hands ownership to the host by setting a lock input. While the host holds the lock, core reads are stalled.

While a program or erase is in progress and the lock is clear, a host read is either held and replayed once the array is free, or refused at once with an abort pulse. A one-bit mode input selects which. A host program/erase request made without the lock is refused with an error pulse. A core request to drop the lock while the host's operation is still running takes effect only after that operation finishes. Every grant, abort and error output is a registered one-cycle pulse. The array's own busy signal (`pe_busy_i`) marks when a program/erase actually runs.

Top module: `flash_lock_arb`

## Requirements
- R1: After reset `lock_o` is 0, all pulse outputs and `core_stall_o` are 0, and the core owns program/erase: a core program/erase request on an idle array is granted (`core_pe_gnt_o`) in the cycle after it is sampled.
- R2: A read request on an idle array is granted in the cycle after it is sampled. A granted read holds the array for ACCESS_CYCLES (default 2) cycles, so consecutive read grants are at least ACCESS_CYCLES cycles apart. A request that arrives during a hold stays pending and is granted when the hold ends.
- R3: When host and core reads are eligible in the same cycle, exactly one is granted. Priority alternates: the side not granted last wins, and the host wins first after reset.
- R4: With `lock_o` 0 and a program/erase active, a host read sampled with `abort_mode_i` = 1 produces a one-cycle `host_abort_o` pulse in the next cycle and is dropped; it is never granted.
- R5: With `abort_mode_i` = 0, a host read that arrives during a program/erase is held, and no read is granted while the operation is active. If `pe_busy_i` is last sampled high at edge k, the held read is granted at edge k+2.
- R6: A host program/erase request sampled while `lock_o` is 0 gives a one-cycle `host_pe_err_o` pulse and no `host_pe_gnt_o`.
- R7: A rising `lock_i` shows on `lock_o` one cycle later. While `lock_o` is 1, a host program/erase request on an idle array is granted, and a core program/erase request is refused with a one-cycle `core_pe_err_o` pulse.
- R8: A core read is never granted while `lock_o` is 1. `core_stall_o` is high while a core read is pending and `lock_o` is 1. The core read is granted after `lock_o` falls.
- R9: If `lock_i` falls while a host program/erase is active, `lock_o` stays 1 until the operation ends. It falls at edge k+2, where `pe_busy_i` was last sampled high at edge k.
- R10: While `lock_o` is 1, a host read that arrives during a program/erase is held and granted afterwards, whatever the value of `abort_mode_i`.
- R11: A program/erase request from either side is refused with its error pulse while a read hold or a program/erase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_rd_req_i | input | 1 | Host read request, one cycle per read |
| core_rd_req_i | input | 1 | Core read request, one cycle per read |
| host_pe_req_i | input | 1 | Host program/erase start request |
| core_pe_req_i | input | 1 | Core program/erase start request |
| pe_busy_i | input | 1 | Array reports program/erase running |
| lock_i | input | 1 | Core-written lock bit, 1 gives the host program/erase ownership |
| abort_mode_i | input | 1 | 1 aborts host reads that meet a busy array, 0 defers them |
| host_rd_gnt_o | output | 1 | Host read granted (pulse) |
| core_rd_gnt_o | output | 1 | Core read granted (pulse) |
| host_pe_gnt_o | output | 1 | Host program/erase granted (pulse) |
| core_pe_gnt_o | output | 1 | Core program/erase granted (pulse) |
| host_abort_o | output | 1 | Host read aborted (pulse) |
| host_pe_err_o | output | 1 | Host program/erase refused (pulse) |
| core_pe_err_o | output | 1 | Core program/erase refused (pulse) |
| core_stall_o | output | 1 | Core read held back by the lock |
| lock_o | output | 1 | Effective lock state |

## Verification
Simultaneous host and core reads are issued twice, once from reset and once after a host-only grant. A fixed-priority arbiter gives the same winner both times, so this pattern exposes it, while a round-robin arbiter flips the winner. Back-to-back host reads, and a program/erase request right after a read grant, check that the access hold is kept. Reads against a core-owned erase are issued once in abort mode and once in defer mode, which separates dropping a read from replaying it. A lock-owned host erase, with the lock cleared while the erase runs, separates a lock that releases immediately from one that waits for completion. In the same run, a host read in abort mode must still be deferred, and a core read must stay stalled until the release.

// File: rtl/flk_pkg.sv
package flk_pkg;
  typedef enum logic [1:0] {
    PE_IDLE = 2'd0,
    PE_WAIT = 2'd1,
    PE_RUN  = 2'd2
  } pe_phase_e;

  localparam int unsigned HOST_IDX = 0;
  localparam int unsigned CORE_IDX = 1;
endpackage

// File: rtl/flk_rr.sv
module flk_rr #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic [IW-1:0] win_idx;
  logic [IW-1:0] idx;
  logic          found;

  always_comb begin
    gnt_o   = '0;
    found   = 1'b0;
    win_idx = last_q;
    idx     = last_q;
    for (int off = 1; off <= int'(N); off++) begin
      idx = IW'((int'(last_q) + off) % int'(N));
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        win_idx    = idx;
        found      = 1'b1;
      end
    end
  end

  // reset to last index so index 0 wins first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IW'(N - 1);
    else if (found) last_q <= win_idx;
  end

  p_rr_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_rr_fair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&req_i) |-> !gnt_o[last_q]);
endmodule

// File: rtl/flk_pe_ctrl.sv
module flk_pe_ctrl
  import flk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_pe_req_i,
  input  logic core_pe_req_i,
  input  logic pe_busy_i,
  input  logic lock_i,
  input  logic rd_busy_i,
  output logic host_pe_gnt_o,
  output logic core_pe_gnt_o,
  output logic host_pe_err_o,
  output logic core_pe_err_o,
  output logic lock_o,
  output logic pe_active_o,
  output logic pe_take_o
);
  pe_phase_e phase_q;
  logic      host_owner_q;
  logic      lock_q;
  logic      flash_idle;
  logic      host_ok;
  logic      core_ok;

  assign flash_idle  = (phase_q == PE_IDLE) && !rd_busy_i;
  assign host_ok     = host_pe_req_i && lock_q && flash_idle;
  assign core_ok     = core_pe_req_i && !lock_q && flash_idle;
  assign pe_take_o   = host_ok || core_ok;
  assign pe_active_o = (phase_q != PE_IDLE);
  assign lock_o      = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q       <= PE_IDLE;
      host_owner_q  <= 1'b0;
      lock_q        <= 1'b0;
      host_pe_gnt_o <= 1'b0;
      core_pe_gnt_o <= 1'b0;
      host_pe_err_o <= 1'b0;
      core_pe_err_o <= 1'b0;
    end else begin
      host_pe_gnt_o <= host_ok;
      core_pe_gnt_o <= core_ok;
      host_pe_err_o <= host_pe_req_i && !host_ok;
      core_pe_err_o <= core_pe_req_i && !core_ok;
      // host-owned operation pins the lock until it ends
      lock_q <= (pe_active_o && host_owner_q) ? 1'b1 : lock_i;
      unique case (phase_q)
        PE_IDLE: if (pe_take_o) begin
          phase_q      <= PE_WAIT;
          host_owner_q <= host_ok;
        end
        PE_WAIT: if (pe_busy_i) phase_q <= PE_RUN;
        PE_RUN: if (!pe_busy_i) begin
          phase_q      <= PE_IDLE;
          host_owner_q <= 1'b0;
        end
        default: phase_q <= PE_IDLE;
      endcase
    end
  end

  p_host_pe_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_pe_gnt_o |-> $past(lock_q));

  p_gnt_err_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_pe_gnt_o && host_pe_err_o) && !(core_pe_gnt_o && core_pe_err_o));

  p_core_pe_unlocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_pe_gnt_o |-> !$past(lock_q));

  p_lock_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_active_o && host_owner_q) |=> lock_q);

  p_pe_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_pe_gnt_o || core_pe_gnt_o) |-> $past(!pe_active_o && !rd_busy_i));

  p_pe_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({host_pe_gnt_o, core_pe_gnt_o}));
endmodule

// File: rtl/flk_rd_arb.sv
module flk_rd_arb
  import flk_pkg::*;
#(
  parameter int unsigned ACC_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_rd_req_i,
  input  logic core_rd_req_i,
  input  logic abort_mode_i,
  input  logic lock_i,
  input  logic pe_active_i,
  input  logic pe_take_i,
  output logic host_rd_gnt_o,
  output logic core_rd_gnt_o,
  output logic host_abort_o,
  output logic core_stall_o,
  output logic rd_busy_o
);
  localparam int unsigned CW = $clog2(ACC_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          host_pend_q;
  logic          core_pend_q;
  logic          host_abort_now;
  logic          host_pend;
  logic          core_pend;
  logic          slot_free;
  logic [1:0]    rr_req;
  logic [1:0]    rr_gnt;

  assign host_abort_now = host_rd_req_i && pe_active_i && !lock_i && abort_mode_i;
  assign host_pend      = host_pend_q || (host_rd_req_i && !host_abort_now);
  assign core_pend      = core_pend_q || core_rd_req_i;
  assign slot_free      = (cnt_q == '0) && !pe_active_i && !pe_take_i;

  always_comb begin
    rr_req = '0;
    if (slot_free) begin
      rr_req[HOST_IDX] = host_pend;
      rr_req[CORE_IDX] = core_pend && !lock_i;
    end
  end

  flk_rr #(.N(2)) u_rr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (rr_req),
    .gnt_o (rr_gnt)
  );

  assign rd_busy_o    = (cnt_q != '0);
  assign core_stall_o = core_pend_q && lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q         <= '0;
      host_pend_q   <= 1'b0;
      core_pend_q   <= 1'b0;
      host_rd_gnt_o <= 1'b0;
      core_rd_gnt_o <= 1'b0;
      host_abort_o  <= 1'b0;
    end else begin
      host_pend_q   <= host_pend && !rr_gnt[HOST_IDX];
      core_pend_q   <= core_pend && !rr_gnt[CORE_IDX];
      host_rd_gnt_o <= rr_gnt[HOST_IDX];
      core_rd_gnt_o <= rr_gnt[CORE_IDX];
      host_abort_o  <= host_abort_now;
      if (|rr_gnt)             cnt_q <= CW'(ACC_CYC - 1);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

  p_one_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_rd_gnt_o && core_rd_gnt_o));

  p_core_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rd_gnt_o |-> !$past(lock_i));

  p_no_rd_in_pe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_gnt_o || core_rd_gnt_o) |-> !$past(pe_active_i));

  p_abort_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_abort_o |-> $past(!lock_i && pe_active_i && abort_mode_i));

  generate
    if (ACC_CYC >= 2) begin : g_hold
      p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_rd_gnt_o || core_rd_gnt_o) |=> !(host_rd_gnt_o || core_rd_gnt_o));
    end
  endgenerate
endmodule

// File: rtl/flash_lock_arb.sv
module flash_lock_arb #(
  parameter int unsigned ACCESS_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_rd_req_i,
  input  logic core_rd_req_i,
  input  logic host_pe_req_i,
  input  logic core_pe_req_i,
  input  logic pe_busy_i,
  input  logic lock_i,
  input  logic abort_mode_i,
  output logic host_rd_gnt_o,
  output logic core_rd_gnt_o,
  output logic host_pe_gnt_o,
  output logic core_pe_gnt_o,
  output logic host_abort_o,
  output logic host_pe_err_o,
  output logic core_pe_err_o,
  output logic core_stall_o,
  output logic lock_o
);
  logic lock_eff;
  logic pe_active;
  logic pe_take;
  logic rd_busy;

  flk_pe_ctrl u_pe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_pe_req_i(host_pe_req_i),
    .core_pe_req_i(core_pe_req_i),
    .pe_busy_i    (pe_busy_i),
    .lock_i       (lock_i),
    .rd_busy_i    (rd_busy),
    .host_pe_gnt_o(host_pe_gnt_o),
    .core_pe_gnt_o(core_pe_gnt_o),
    .host_pe_err_o(host_pe_err_o),
    .core_pe_err_o(core_pe_err_o),
    .lock_o       (lock_eff),
    .pe_active_o  (pe_active),
    .pe_take_o    (pe_take)
  );

  flk_rd_arb #(.ACC_CYC(ACCESS_CYCLES)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_rd_req_i(host_rd_req_i),
    .core_rd_req_i(core_rd_req_i),
    .abort_mode_i (abort_mode_i),
    .lock_i       (lock_eff),
    .pe_active_i  (pe_active),
    .pe_take_i    (pe_take),
    .host_rd_gnt_o(host_rd_gnt_o),
    .core_rd_gnt_o(core_rd_gnt_o),
    .host_abort_o (host_abort_o),
    .core_stall_o (core_stall_o),
    .rd_busy_o    (rd_busy)
  );

  assign lock_o = lock_eff;
endmodule

// File: tb/test_flash_lock_arb.sv
`timescale 1ns/1ps
module test_flash_lock_arb;
  localparam logic [6:0] HR = 7'b1000000;
  localparam logic [6:0] CR = 7'b0100000;
  localparam logic [6:0] HP = 7'b0010000;
  localparam logic [6:0] CP = 7'b0001000;
  localparam logic [6:0] AB = 7'b0000100;
  localparam logic [6:0] HE = 7'b0000010;
  localparam logic [6:0] CE = 7'b0000001;

  typedef struct {
    int         cyc;
    logic [6:0] v;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rd = 0, core_rd = 0, host_pe = 0, core_pe = 0;
  logic pe_busy = 0, lock = 0, abort_mode = 0;
  logic host_rd_gnt, core_rd_gnt, host_pe_gnt, core_pe_gnt;
  logic host_abort, host_pe_err, core_pe_err, core_stall, lock_eff;
  logic [6:0] pulses;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  flash_lock_arb i_flash_lock_arb (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .host_rd_req_i(host_rd),
    .core_rd_req_i(core_rd),
    .host_pe_req_i(host_pe),
    .core_pe_req_i(core_pe),
    .pe_busy_i    (pe_busy),
    .lock_i       (lock),
    .abort_mode_i (abort_mode),
    .host_rd_gnt_o(host_rd_gnt),
    .core_rd_gnt_o(core_rd_gnt),
    .host_pe_gnt_o(host_pe_gnt),
    .core_pe_gnt_o(core_pe_gnt),
    .host_abort_o (host_abort),
    .host_pe_err_o(host_pe_err),
    .core_pe_err_o(core_pe_err),
    .core_stall_o (core_stall),
    .lock_o       (lock_eff)
  );

  assign pulses = {host_rd_gnt, core_rd_gnt, host_pe_gnt, core_pe_gnt,
                   host_abort, host_pe_err, core_pe_err};

  task automatic check_vec(string tag, logic [6:0] act, logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_at(int d, logic [6:0] v, string tag);
    q.push_back('{cyc + d, v, tag});
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops expected pulses as cycles pass
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
        check_vec({q[0].tag, " missing"}, 7'b0, q[0].v);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].cyc == cyc) begin
        check_vec(q[0].tag, pulses, q[0].v);
        void'(q.pop_front());
      end else if (pulses != 7'b0) begin
        check_vec("R4 R6 spurious pulse", pulses, 7'b0);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    tick();
    check_bit("R1 lock after reset", lock_eff, 1'b0);
    check_bit("R1 stall after reset", core_stall, 1'b0);
    check_vec("R1 pulses after reset", pulses, 7'b0);
    idle(2);

    // simultaneous reads from reset: host first, core after hold
    host_rd = 1; core_rd = 1;
    expect_at(1, HR, "R3 host wins first");
    expect_at(3, CR, "R2 core after hold");
    tick(); host_rd = 0; core_rd = 0;
    idle(5);

    host_rd = 1;
    expect_at(1, HR, "R2 single host read");
    tick(); host_rd = 0;
    idle(4);

    // host was last: core must win now
    host_rd = 1; core_rd = 1;
    expect_at(1, CR, "R3 alternate to core");
    expect_at(3, HR, "R3 host second");
    tick(); host_rd = 0; core_rd = 0;
    idle(5);

    host_rd = 1;
    expect_at(1, HR, "R2 first of pair");
    tick();
    expect_at(2, HR, "R2 back-to-back held");
    tick(); host_rd = 0;
    idle(5);

    host_rd = 1;
    expect_at(1, HR, "R11 read before pe");
    tick(); host_rd = 0; core_pe = 1;
    expect_at(1, CE, "R11 pe refused during hold");
    tick(); core_pe = 0;
    idle(4);

    // core-owned erase
    core_pe = 1;
    expect_at(1, CP, "R1 core owns pe");
    tick(); core_pe = 0; pe_busy = 1;
    tick();
    abort_mode = 1; host_rd = 1;
    expect_at(1, AB, "R4 abort pulse");
    tick(); host_rd = 0; host_pe = 1;
    expect_at(1, HE, "R6 host pe without lock");
    tick(); host_pe = 0; abort_mode = 0; host_rd = 1;
    tick(); host_rd = 0;
    idle(3);
    pe_busy = 0;
    expect_at(2, HR, "R5 deferred read replayed");
    tick();
    idle(5);

    // host-owned erase under lock
    lock = 1;
    tick();
    check_bit("R7 lock visible", lock_eff, 1'b1);
    core_rd = 1;
    tick(); core_rd = 0;
    check_bit("R8 core stalled", core_stall, 1'b1);
    host_pe = 1;
    expect_at(1, HP, "R7 host pe granted");
    tick(); host_pe = 0; pe_busy = 1;
    tick();
    core_pe = 1;
    expect_at(1, CE, "R7 core pe refused");
    tick(); core_pe = 0; abort_mode = 1; host_rd = 1;
    tick(); host_rd = 0; lock = 0;
    idle(2);
    check_bit("R9 lock held during host pe", lock_eff, 1'b1);
    check_bit("R8 stall held", core_stall, 1'b1);
    pe_busy = 0;
    expect_at(2, HR, "R10 host read deferred under lock");
    expect_at(4, CR, "R8 core read after unlock");
    tick();
    check_bit("R9 lock held at end", lock_eff, 1'b1);
    tick();
    check_bit("R9 lock released", lock_eff, 1'b0);
    idle(5);
    abort_mode = 0;

    idle(3);
    check_bit("R2 all expected pulses seen", (q.size() == 0), 1'b1);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule